// File: doc/BRIEF.md
# Guest-Adjusted Time Counter Reader

This block gives software a word-wide view of a free-running 64-bit time counter. When the hart executes in guest (virtualized) mode, every read returns the counter plus a per-guest offset that the hypervisor has programmed. Outside guest mode, reads return the raw counter. The time source, timer compare logic and interrupts lie outside the block.

With the default 32-bit word, software sees the counter as a low word and a high word. The offset is held as two halves, low and high, and each half is written separately through a simple write port. The high-word read takes bits 63:32 of the full 64-bit sum, so a carry out of the low half reaches the high word. A read request is answered one cycle later on `rd_data` with `rd_valid`. When the word is as wide as the counter, the offset is one register and high-half writes have no effect.

Top module: `vtime_reader`

## Requirements
- R1: After reset, both offset halves are zero, `rd_valid` is 0, and a guest-mode read returns the raw counter.
- R2: With `virt_mode`=0 and `rd_hi`=0, the read data is `time_in[31:0]` sampled at the request edge, whatever the offset holds.
- R3: With `virt_mode`=0 and `rd_hi`=1, the read data is `time_in[63:32]` sampled at the request edge, whatever the offset holds.
- R4: With `virt_mode`=1 and `rd_hi`=0, the read data is (`time_in[31:0]` + low offset) mod 2^32.
- R5: With `virt_mode`=1 and `rd_hi`=1, the read data is bits 63:32 of the 64-bit sum `time_in` + {high offset, low offset}, including any carry out of bit 31.
- R6: The 64-bit sum wraps modulo 2^64, and there is no overflow indication.
- R7: A write (`wr_en`=1) stores `wr_data` into the low half (`wr_hi`=0) or the high half (`wr_hi`=1) at the clock edge. A read issued in the same cycle uses the old offset. A read issued in the next cycle uses the new one.
- R8: `rd_valid` is 1 exactly one cycle after a cycle with `rd_en`=1. `rd_data` holds its value while no read is issued.
- R9: A write to one offset half leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| time_in | input | 64 | Free-running time counter value |
| virt_mode | input | 1 | 1 when the hart runs in guest mode |
| rd_en | input | 1 | Read request |
| rd_hi | input | 1 | 0 selects the low time word, 1 selects the high word |
| wr_en | input | 1 | Offset write strobe |
| wr_hi | input | 1 | 0 writes the low offset half, 1 writes the high half |
| wr_data | input | 32 | Offset write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read result |

## Verification
A read result is due one clock after the request edge. An offset write takes effect at its own edge, so the earliest read that sees the new offset is issued one cycle after the write. The driver applies inputs at the falling edge and queues the value the requirement predicts, using the offset as it stood before any write in the same cycle. The monitor samples 1 ns after each rising edge and pops one expected item for every cycle in which `rd_valid` is high, so each result is compared against exactly the request that produced it. Carry from the low half into the high half, the wrap at 2^64, and a read issued alongside a write each get their own directed cases.

// File: rtl/vtime_pkg.sv
package vtime_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  typedef struct packed {
    logic  virt;
    half_e half;
  } rd_req_t;
endpackage

// File: rtl/vtime_offset_regs.sv
module vtime_offset_regs
  import vtime_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  half_e             wr_half,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  offset
);
  localparam int HI_W = CNT_W - WORD_W;

  generate
    if (HI_W > 0) begin : g_split
      logic [WORD_W-1:0] lo_q, lo_d;
      logic [HI_W-1:0]   hi_q, hi_d;
      logic              lo_en, hi_en;

      always_comb begin
        lo_en = wr_en && (wr_half == HALF_LO);
        hi_en = wr_en && (wr_half == HALF_HI);
        lo_d  = wr_data;
        hi_d  = wr_data[HI_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          if (lo_en) lo_q <= lo_d;
          if (hi_en) hi_q <= hi_d;
        end
      end

      assign offset = {hi_q, lo_q};

      assert_hi_write_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half == HALF_HI) |=> $stable(lo_q));
      assert_lo_write_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half == HALF_LO) |=> $stable(hi_q));
      assert_lo_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half == HALF_LO) |=> (lo_q == $past(wr_data)));
    end else begin : g_whole
      logic [CNT_W-1:0] off_q, off_d;
      logic             off_en;

      always_comb begin
        off_en = wr_en && (wr_half == HALF_LO);
        off_d  = wr_data[CNT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else if (off_en) off_q <= off_d;
      end

      assign offset = off_q;
    end
  endgenerate

  assert_idle_holds_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(offset));
endmodule

// File: rtl/vtime_adder.sv
module vtime_adder #(
  parameter int CNT_W = 64
) (
  input  logic             virt,
  input  logic [CNT_W-1:0] time_val,
  input  logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] adjusted
);
  logic [CNT_W-1:0] sum;

  always_comb begin
    sum      = time_val + offset;
    adjusted = virt ? sum : time_val;
  end
endmodule

// File: rtl/vtime_read_port.sv
module vtime_read_port
  import vtime_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  half_e             rd_half,
  input  logic [CNT_W-1:0]  value,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [WORD_W-1:0] word_sel;
  logic [WORD_W-1:0] data_d;
  logic              valid_d;

  generate
    if (HI_W > 0) begin : g_two_words
      always_comb begin
        word_sel = '0;
        if (rd_half == HALF_HI) word_sel[HI_W-1:0] = value[CNT_W-1:WORD_W];
        else                    word_sel = value[WORD_W-1:0];
      end
    end else begin : g_one_word
      always_comb begin
        word_sel = '0;
        if (rd_half == HALF_LO) word_sel = value[WORD_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    valid_d = rd_en;
    data_d  = rd_en ? word_sel : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end

  assert_valid_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/vtime_reader.sv
module vtime_reader
  import vtime_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  time_in,
  input  logic              virt_mode,
  input  logic              rd_en,
  input  logic              rd_hi,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CNT_W-1:0] offset;
  logic [CNT_W-1:0] adjusted;
  rd_req_t          req;
  half_e            wr_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    req.virt = virt_mode;
    req.half = rd_hi ? HALF_HI : HALF_LO;
    wr_half  = wr_hi ? HALF_HI : HALF_LO;
  end

  vtime_offset_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_offset (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_half (wr_half),
    .wr_data (wr_data),
    .offset  (offset)
  );

  vtime_adder #(.CNT_W(CNT_W)) u_adder (
    .virt     (req.virt),
    .time_val (time_in),
    .offset   (offset),
    .adjusted (adjusted)
  );

  vtime_read_port #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .rd_half  (req.half),
    .value    (adjusted),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assert_raw_low_word_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !virt_mode && !rd_hi) |=> (rd_data == $past(time_in[WORD_W-1:0])));
  assert_guest_low_word_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && virt_mode && !rd_hi) |=>
      (rd_data == $past(time_in[WORD_W-1:0] + offset[WORD_W-1:0])));
  assert_reset_valid_low_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (!rd_valid || rst_sync_n));
endmodule

// File: tb/vtime_reader_tb.sv
`timescale 1ns/1ps
module vtime_reader_tb_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] time_in;
  logic        virt_mode, rd_en, rd_hi, wr_en, wr_hi;
  logic [31:0] wr_data;
  logic        rd_valid;
  logic [31:0] rd_data;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  logic [31:0] m_off_lo, m_off_hi;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  vtime_reader dut_i (
    .clk(clk), .rst_n(rst_n), .time_in(time_in), .virt_mode(virt_mode),
    .rd_en(rd_en), .rd_hi(rd_hi), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input bit hi, input bit virt, input logic [63:0] t);
    logic [63:0] s;
    s = virt ? (t + {m_off_hi, m_off_lo}) : t;
    return hi ? s[63:32] : s[31:0];
  endfunction

  // Drive one cycle of stimulus; read uses offset before any same-cycle write (R7)
  task automatic cycle(input bit rd, input bit hi, input bit virt, input logic [63:0] t,
                       input bit wr, input bit whi, input logic [31:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    time_in = t; virt_mode = virt; rd_en = rd; rd_hi = hi;
    wr_en = wr; wr_hi = whi; wr_data = wd;
    if (rd) begin
      e.val = model(hi, virt, t);
      e.tag = tag;
      exp_q.push_back(e);
    end
    if (wr) begin
      if (whi) m_off_hi = wd;
      else     m_off_lo = wd;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  // Monitor: scoreboard pops one item per valid result
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rd_valid) begin
        if (exp_q.size() == 0) check(0, "R8 unexpected rd_valid", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rd_data == e.val, e.tag, rd_data, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    m_off_lo = 0; m_off_hi = 0;
    rst_n = 0; time_in = 0; virt_mode = 0; rd_en = 0; rd_hi = 0;
    wr_en = 0; wr_hi = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    check(rd_valid == 0 && rd_data == 0, "R1 reset outputs", {rd_valid, rd_data}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check(rd_valid == 0, "R1 valid low after reset release", rd_valid, 0);

    cycle(1, 0, 1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, "R1 guest low, zero offset");
    cycle(1, 1, 1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, "R1 guest high, zero offset");

    cycle(0, 0, 0, 0, 1, 0, 32'h0000_0020, "setup");
    cycle(0, 0, 0, 0, 1, 1, 32'h0000_0100, "setup");
    cycle(1, 0, 0, 64'hAAAA_BBBB_FFFF_FFF0, 0, 0, 0, "R2 raw low ignores offset");
    cycle(1, 1, 0, 64'hAAAA_BBBB_FFFF_FFF0, 0, 0, 0, "R3 raw high ignores offset");
    cycle(1, 0, 1, 64'hAAAA_BBBB_FFFF_FFF0, 0, 0, 0, "R4 guest low wraps 2^32");
    cycle(1, 1, 1, 64'h0000_0001_FFFF_FFF0, 0, 0, 0, "R5 guest high with carry");
    cycle(1, 1, 1, 64'h0000_0001_0000_0000, 0, 0, 0, "R5 guest high no carry");

    cycle(0, 0, 0, 0, 1, 0, 32'h0000_0001, "setup");
    cycle(0, 0, 0, 0, 1, 1, 32'h0000_0000, "setup");
    cycle(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R6 wrap low");
    cycle(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R6 wrap high");

    cycle(1, 0, 1, 64'h0000_0000_0000_1000, 1, 0, 32'h0000_0500, "R7 read with write uses old");
    cycle(1, 0, 1, 64'h0000_0000_0000_1000, 0, 0, 0, "R7 read after write uses new");

    cycle(0, 0, 0, 0, 1, 1, 32'hDEAD_0000, "setup");
    cycle(1, 0, 1, 64'h0000_0000_0000_0001, 0, 0, 0, "R9 low kept after high write");
    cycle(1, 1, 1, 64'h0000_0003_0000_0001, 0, 0, 0, "R9 high written");
    cycle(0, 0, 0, 0, 1, 0, 32'h0000_0007, "setup");
    cycle(1, 1, 1, 64'h0000_0003_0000_0001, 0, 0, 0, "R9 high kept after low write");

    idle();
    @(posedge clk); #1;
    held = rd_data;
    repeat (3) @(posedge clk);
    #1;
    check(rd_data == held, "R8 data held while idle", rd_data, held);
    check(rd_valid == 0, "R8 valid low while idle", rd_valid, 0);
    check(exp_q.size() == 0, "R8 every read answered", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule